// File: doc/BRIEF.md
# Dual-Clock Loss-of-Clock Monitor

This block watches two clocks that feed a phase-frequency detector: the reference clock and the feedback clock. It does not measure frequency in analog terms. Each watched clock is brought into a free-running monitor clock domain and reduced to a pulse on each rising edge. A per-clock counter then times the gap between edges in monitor cycles. When a gap grows beyond a programmable limit, a single sticky loss flag is raised.

Monitoring runs only while the enable input is high and the external-clock-mode input is low. Dropping out of monitoring clears both gap counters, so turning monitoring back on starts from a clean state. Software removes the flag with a write-one-to-clear pulse. If a loss is still being seen in the cycle of the clear, the loss wins.

Top module: `clk_loss_monitor`

## Requirements
- R1: With `enable_i` low, neither clock stopping sets `loss_flag_o`.
- R2: While monitoring is active, a stopped or too-slow `ref_clk_i` sets `loss_flag_o`, and a healthy `ref_clk_i` does not.
- R3: While monitoring is active, a stopped or too-slow `fb_clk_i` sets `loss_flag_o`, whatever the state of the other clock.
- R4: Once set, `loss_flag_o` stays set after the lost clock recovers, until it is cleared or reset.
- R5: While `ext_mode_i` is high, monitoring is off and `loss_flag_o` never rises, whatever `enable_i` is.
- R6: A clock is counted as lost once more than `limit_i` monitor cycles pass without a synchronized rising edge (a 0 to 1 change after the synchronizer). The flag therefore does not rise while edges arrive at shorter intervals.
- R7: A one-cycle high pulse on `clear_i` clears `loss_flag_o` in the next cycle. If a loss is detected in the same cycle as the clear, the flag stays set.
- R8: Taking monitoring down (enable low or external mode) clears both gap counters. Re-enabling after a long stop, with the clocks running, does not raise the flag.
- R9: After `rst_ni` is asserted, `loss_flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Watched reference clock (asynchronous) |
| fb_clk_i | input | 1 | Watched feedback clock (asynchronous) |
| enable_i | input | 1 | Monitoring enable |
| ext_mode_i | input | 1 | External clock mode; forces monitoring off |
| clear_i | input | 1 | Write-one-to-clear pulse for the flag |
| limit_i | input | CNT_W | Largest allowed gap, in monitor cycles |
| loss_flag_o | output | 1 | Sticky loss-of-clock flag |

## Verification
The bench builds the block with the default 16-bit counter and two synchronizer stages, and programs `limit_i` to 8. This keeps a stall detectable within a few tens of cycles. With that limit, a watched clock that toggles every 2 monitor cycles is healthy, and one that toggles every 12 cycles counts as too slow. Both sides of the threshold, stopped clocks and the clear/loss collision can all be reached in short runs.

// File: rtl/clk_loss_pkg.sv
package clk_loss_pkg;
  localparam int unsigned NUM_SRC      = 2;
  localparam int unsigned SYNC_DEF     = 2;
  localparam int unsigned CNT_W_DEF    = 16;
  typedef enum logic {SRC_REF = 1'b0, SRC_FB = 1'b1} src_e;
endpackage

// File: rtl/clk_edge_sync.sv
module clk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  assert_rise_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/edge_timeout.sv
module edge_timeout #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!active_i || edge_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = active_i && (cnt_q > limit_i);

  assert_cnt_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));
  assert_cnt_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && edge_i) |=> (cnt_q == '0));
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
  import clk_loss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  parameter int unsigned CNT_W       = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             fb_clk_i,
  input  logic             enable_i,
  input  logic             ext_mode_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             loss_flag_o
);
  logic               active;
  logic [NUM_SRC-1:0] watched;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] expired;
  logic               loss_any;
  logic               flag_q;

  assign active           = enable_i & ~ext_mode_i;
  assign watched[SRC_REF] = ref_clk_i;
  assign watched[SRC_FB]  = fb_clk_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    clk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(watched[g]),
      .rise_o (rise[g])
    );
    edge_timeout #(.CNT_W(CNT_W)) u_tmo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active),
      .edge_i   (rise[g]),
      .limit_i  (limit_i),
      .expired_o(expired[g])
    );
  end

  assign loss_any = |expired;

  // new loss has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (loss_any) flag_q <= 1'b1;
    else if (clear_i)  flag_q <= 1'b0;
  end

  assign loss_flag_o = flag_q;

  assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_flag_o && !clear_i) |=> loss_flag_o);
  assert_loss_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_any |=> loss_flag_o);
  assert_clear_works_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !loss_any) |=> !loss_flag_o);
  assert_off_when_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !loss_flag_o) |=> !loss_flag_o);
  assert_off_in_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && !loss_flag_o) |=> !loss_flag_o);
endmodule

// File: tb/clk_loss_monitor_tb_top.sv
module clk_loss_monitor_tb_top;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] LIMIT = 16'd8;
  // vector: {ref_mode[1:0], fb_mode[1:0], enable, ext_mode, expected_flag}
  // mode: 0 stopped, 1 toggles every 2 cycles, 2 toggles every 12 cycles
  localparam int NVEC = 7;
  localparam logic [6:0] VECS [0:NVEC-1] = '{
    {2'd1, 2'd1, 1'b1, 1'b0, 1'b0},  // R2 healthy
    {2'd0, 2'd1, 1'b1, 1'b0, 1'b1},  // R2 ref stopped
    {2'd1, 2'd0, 1'b1, 1'b0, 1'b1},  // R3 fb stopped
    {2'd2, 2'd1, 1'b1, 1'b0, 1'b1},  // R6 ref too slow
    {2'd1, 2'd2, 1'b1, 1'b0, 1'b1},  // R3 fb too slow
    {2'd0, 2'd0, 1'b0, 1'b0, 1'b0},  // R1 disabled
    {2'd0, 2'd0, 1'b1, 1'b1, 1'b0}   // R5 external mode
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0, fb_clk = 1'b0;
  logic enable = 1'b0, ext_mode = 1'b0, clear = 1'b0;
  logic [1:0] ref_mode = 2'd1, fb_mode = 2'd1;
  logic loss_flag;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  clk_loss_monitor #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk),
    .enable_i(enable), .ext_mode_i(ext_mode), .clear_i(clear),
    .limit_i(LIMIT), .loss_flag_o(loss_flag)
  );

  function automatic int half_of(input logic [1:0] m);
    return (m == 2'd2) ? 12 : 2;
  endfunction

  initial begin
    int rc = 0, fc = 0;
    forever begin
      @(negedge clk);
      if (ref_mode != 2'd0) begin
        rc++;
        if (rc >= half_of(ref_mode)) begin ref_clk = ~ref_clk; rc = 0; end
      end
      if (fb_mode != 2'd0) begin
        fc++;
        if (fc >= half_of(fb_mode)) begin fb_clk = ~fb_clk; fc = 0; end
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    checks++;
    if (loss_flag !== exp) begin
      errors++;
      $display("FAIL %s: loss_flag actual=%0b expected=%0b", req, loss_flag, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic settle_healthy();
    ref_mode = 2'd1; fb_mode = 2'd1; enable = 1'b1; ext_mode = 1'b0;
    wait_cyc(20);
    pulse_clear();
    wait_cyc(3);
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    check(1'b0, "R9 reset state");
    rst_n = 1'b1;
    wait_cyc(2);

    for (int v = 0; v < NVEC; v++) begin
      settle_healthy();
      check(1'b0, "R7 clear before vector");
      ref_mode = VECS[v][6:5]; fb_mode = VECS[v][4:3];
      enable = VECS[v][2]; ext_mode = VECS[v][1];
      wait_cyc(60);
      check(VECS[v][0], $sformatf("vector %0d (R1/R2/R3/R5/R6)", v));
    end

    // R6 timing: no early flag, then flag within bound
    settle_healthy();
    ref_mode = 2'd0;
    wait_cyc(3);
    check(1'b0, "R6 no flag before limit");
    wait_cyc(int'(LIMIT) + 8);
    check(1'b1, "R6 flag after limit");

    // R4 sticky after recovery
    ref_mode = 2'd1;
    wait_cyc(40);
    check(1'b1, "R4 sticky after recovery");

    // R7 clear with clocks healthy
    pulse_clear();
    wait_cyc(2);
    check(1'b0, "R7 clear");

    // R7 clear colliding with an ongoing loss
    fb_mode = 2'd0;
    wait_cyc(40);
    pulse_clear();
    wait_cyc(1);
    check(1'b1, "R7 loss wins over clear");

    // R8 long stop while disabled, then re-enable with clocks running
    enable = 1'b0; ref_mode = 2'd0; fb_mode = 2'd0;
    pulse_clear();
    wait_cyc(80);
    check(1'b0, "R1 disabled long stop");
    ref_mode = 2'd1; fb_mode = 2'd1; enable = 1'b1;
    wait_cyc(40);
    check(1'b0, "R8 re-enable no false loss");

    // R5 external mode overrides enable, then R8 leaving it
    ext_mode = 1'b1; ref_mode = 2'd0;
    wait_cyc(60);
    check(1'b0, "R5 ext mode with enable");
    ref_mode = 2'd1; ext_mode = 1'b0;
    wait_cyc(40);
    check(1'b0, "R8 leaving ext mode");

    // R9 reset clears a set flag
    ref_mode = 2'd0;
    wait_cyc(40);
    check(1'b1, "R2 loss before reset");
    rst_n = 1'b0;
    wait_cyc(2);
    check(1'b0, "R9 reset clears flag");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule